// File: doc/BRIEF.md
# Comparator-Triggered Multiphase Unit-Clock Generator

This block drives the unit clocks of an interleaved switched-capacitor regulator. A clocked comparator samples the regulated rail against a hysteresis level once per sample clock. Each time it reports the rail below the level, the block takes one step through a twisted ring of `PHASES` stages. Each step flips exactly one converter unit between its charging and discharging state. When the comparator reports the rail above the level, every unit clock holds.

Held triggers give each unit a square wave with equal high and low time, a period of twice `PHASES` samples, and a one-sample offset between neighbouring units. The highest switching rate per unit is therefore the sample rate divided by 2·`PHASES`. The converter gear (three-to-two or two-to-one) is registered on every edge. In three-to-two gear the odd-numbered unit clocks are inverted, so the two unequal half-cycle currents spread evenly across the units. A registered trigger count is provided so that the effective switching rate can be measured.

Top module: `phase_interleaver`

## Requirements
- R1: A synchronous reset clears every ring stage and the trigger count, and sets the gear latch to three-to-two. In the first cycle after reset, even-numbered unit clocks read 0 and odd-numbered ones read 1.
- R2: On a sample edge with `cmpBelow`=1 the ring advances one step. Stage 0 loads the inverse of stage `PHASES`-1, each stage k≥1 loads stage k-1, and exactly one stage changes value.
- R3: On a sample edge with `cmpBelow`=0, no ring stage and no bit of `trigCount` changes.
- R4: With `cmpBelow` held at 1, ring stage k equals ring stage k-1 from one sample earlier, and each unit clock toggles every `PHASES` samples (period 2·`PHASES`).
- R5: `trigCount` increases by one for each sample edge with `cmpBelow`=1 and wraps modulo 2^`COUNT_W`.
- R6: `gearSel` is registered on every edge. With the latch at 1, `unitClk[k]` = stage k XOR 1 for odd k and stage k for even k. With the latch at 0, `unitClk[k]` = stage k for all k. Gear never alters the ring stages or `trigCount`.
- R7: A trigger sampled on an edge is visible on `unitClk` and `trigCount` straight after that same edge, through one register stage.
- R8: With `cmpBelow` held at 1, every unit clock is high for exactly `PHASES` of any 2·`PHASES` consecutive samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sampleClk | input | 1 | Comparator sample clock |
| rst | input | 1 | Synchronous active-high reset |
| cmpBelow | input | 1 | Comparator decision, 1 = rail below hysteresis level |
| gearSel | input | 1 | 1 = three-to-two gear, 0 = two-to-one gear |
| unitClk | output | PHASES | Per-unit charge/discharge clocks |
| trigCount | output | COUNT_W | Registered count of trigger events |

## Verification
The checker assumes that `cmpBelow` and `gearSel` are stable and known at each sample edge and change only between edges. The bench drives both inputs at the falling edge, so this always holds. The checker also assumes the ring is only ever seen in states reachable from reset. It recovers the raw ring stages from the outputs using the registered gear, so it assumes that latch is updated once per edge. The stimulus mixes random trigger and gear patterns with long held-trigger runs, including a full counter wrap, and never forces the ring into an unreachable state.

// File: rtl/phase_interleaver_pkg.sv
package phase_interleaver_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic clear;    // return ring and count to their reset values
    logic advance;  // take one ring step and count one trigger
  } stepStrobe_t;

  // Mask with every odd-numbered bit set
  function automatic logic [63:0] oddMask64();
    logic [63:0] m;
    for (int i = 0; i < 64; i++) m[i] = (i % 2 == 1);
    return m;
  endfunction

endpackage

// File: rtl/phase_interleaver_ctrl.sv
module phase_interleaver_ctrl
  import phase_interleaver_pkg::*;
(
  input  logic        sampleClk,
  input  logic        rst,
  input  logic        cmpBelow,
  input  logic        gearSel,
  output stepStrobe_t strobe,
  output logic        gearQ
);

  // Trigger qualification is combinational so the reaction lands on the
  // same edge that sampled the decision.
  always_comb begin
    strobe.clear   = rst;
    strobe.advance = cmpBelow & ~rst;
  end

  // Gear latch, three-to-two after reset
  always_ff @(posedge sampleClk) begin
    if (rst) gearQ <= 1'b1;
    else     gearQ <= gearSel;
  end

endmodule

// File: rtl/phase_interleaver_ring.sv
module phase_interleaver_ring
  import phase_interleaver_pkg::*;
#(
  parameter int PHASES  = 16,
  parameter int COUNT_W = 16
) (
  input  logic               sampleClk,
  input  stepStrobe_t        strobe,
  input  logic               gearQ,
  output logic [PHASES-1:0]  unitClk,
  output logic [COUNT_W-1:0] trigCount
);

  localparam int LAST = PHASES - 1;

  logic [PHASES-1:0] stage;

  // Twisted ring: stage 0 loads the inverse of the last stage
  always_ff @(posedge sampleClk) begin
    if (strobe.clear)        stage <= '0;
    else if (strobe.advance) stage <= {stage[LAST-1:0], ~stage[LAST]};
  end

  always_ff @(posedge sampleClk) begin
    if (strobe.clear)        trigCount <= '0;
    else if (strobe.advance) trigCount <= trigCount + 1'b1;
  end

  // Odd-numbered outputs invert in three-to-two gear
  for (genvar k = 0; k < PHASES; k++) begin : g_out
    if (k % 2 == 1) begin : g_odd
      assign unitClk[k] = stage[k] ^ gearQ;
    end else begin : g_even
      assign unitClk[k] = stage[k];
    end
  end

endmodule

// File: rtl/phase_interleaver.sv
module phase_interleaver
  import phase_interleaver_pkg::*;
#(
  parameter int PHASES  = 16,
  parameter int COUNT_W = 16
) (
  input  logic               sampleClk,
  input  logic               rst,
  input  logic               cmpBelow,
  input  logic               gearSel,
  output logic [PHASES-1:0]  unitClk,
  output logic [COUNT_W-1:0] trigCount
);

  stepStrobe_t strobe;
  logic        gearLive;

  phase_interleaver_ctrl u_ctrl (
    .sampleClk (sampleClk),
    .rst       (rst),
    .cmpBelow  (cmpBelow),
    .gearSel   (gearSel),
    .strobe    (strobe),
    .gearQ     (gearLive)
  );

  phase_interleaver_ring #(
    .PHASES  (PHASES),
    .COUNT_W (COUNT_W)
  ) u_ring (
    .sampleClk (sampleClk),
    .strobe    (strobe),
    .gearQ     (gearLive),
    .unitClk   (unitClk),
    .trigCount (trigCount)
  );

endmodule

// File: rtl/phase_interleaver_chk.sv
module phase_interleaver_chk
  import phase_interleaver_pkg::*;
#(
  parameter int PHASES  = 16,
  parameter int COUNT_W = 16
) (
  input logic               sampleClk,
  input logic               rst,
  input logic               cmpBelow,
  input logic               gearLive,
  input logic [PHASES-1:0]  unitClk,
  input logic [COUNT_W-1:0] trigCount
);

  localparam logic [63:0] ODD_ALL = oddMask64();
  localparam logic [PHASES-1:0] ODD = ODD_ALL[PHASES-1:0];
  localparam logic [PHASES-1:0] EVEN = ~ODD;

  // Raw ring stages recovered from the outputs and the gear latch
  logic [PHASES-1:0] raw;
  assign raw = unitClk ^ (gearLive ? ODD : '0);

  logic rstSeen;
  always_ff @(posedge sampleClk) rstSeen <= rst;

  // R1
  always_ff @(posedge sampleClk) begin
    if (rstSeen === 1'b1 && rst === 1'b0)
      reset_state_chk: assert (unitClk == ODD && trigCount == '0);
  end

  // R2
  one_step_chk: assert property (@(posedge sampleClk) disable iff (rst)
    cmpBelow |=> $countones(raw ^ $past(raw)) == 1);

  // R2
  wrap_in_chk: assert property (@(posedge sampleClk) disable iff (rst)
    cmpBelow |=> raw[0] == !$past(raw[PHASES-1]));

  // R4
  for (genvar k = 1; k < PHASES; k++) begin : g_lag
    lag_chk: assert property (@(posedge sampleClk) disable iff (rst)
      cmpBelow |=> raw[k] == $past(raw[k-1]));
  end

  // R3
  hold_chk: assert property (@(posedge sampleClk) disable iff (rst)
    !cmpBelow |=> $stable(raw) && $stable(trigCount));

  // R6
  even_gear_chk: assert property (@(posedge sampleClk) disable iff (rst)
    !cmpBelow |=> $stable(unitClk & EVEN));

  // R5
  count_chk: assert property (@(posedge sampleClk) disable iff (rst)
    cmpBelow |=> trigCount == $past(trigCount) + 1'b1);

endmodule

bind phase_interleaver phase_interleaver_chk #(
  .PHASES  (PHASES),
  .COUNT_W (COUNT_W)
) u_chk (
  .sampleClk (sampleClk),
  .rst       (rst),
  .cmpBelow  (cmpBelow),
  .gearLive  (gearLive),
  .unitClk   (unitClk),
  .trigCount (trigCount)
);

// File: tb/phase_interleaver_tb.sv
`timescale 1ns/1ps
module phase_interleaver_tb;

  localparam int PHASES  = 16;
  localparam int COUNT_W = 16;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               cmpBelow = 1'b0;
  logic               gearSel = 1'b1;
  logic [PHASES-1:0]  unitClk;
  logic [COUNT_W-1:0] trigCount;

  int checks = 0;
  int fails  = 0;

  logic [PHASES-1:0]  mRing  = '0;
  logic               mGear  = 1'b1;
  logic [COUNT_W-1:0] mCount = '0;

  always #2 clk = ~clk;

  phase_interleaver #(.PHASES(PHASES), .COUNT_W(COUNT_W)) u_dut (
    .sampleClk (sampleClk_w),
    .rst       (rst),
    .cmpBelow  (cmpBelow),
    .gearSel   (gearSel),
    .unitClk   (unitClk),
    .trigCount (trigCount)
  );
  wire sampleClk_w = clk;

  function automatic logic [PHASES-1:0] oddBits();
    logic [PHASES-1:0] m;
    for (int i = 0; i < PHASES; i++) m[i] = (i % 2 == 1);
    return m;
  endfunction

  function automatic logic [PHASES-1:0] stepRing(input logic [PHASES-1:0] r);
    return {r[PHASES-2:0], ~r[PHASES-1]};
  endfunction

  function automatic logic [PHASES-1:0] expectOut();
    return mRing ^ (mGear ? oddBits() : '0);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, update the model at the rising edge, return at the next falling edge
  task automatic step(input logic trig, input logic gear);
    cmpBelow = trig;
    gearSel  = gear;
    @(posedge clk);
    if (rst) begin
      mRing = '0; mGear = 1'b1; mCount = '0;
    end else begin
      mGear = gear;
      if (trig) begin
        mRing  = stepRing(mRing);
        mCount = mCount + 1'b1;
      end
    end
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) step(1'b1, 1'b0);
    rst = 1'b0;
  endtask

  task automatic checkAll(input string tag);
    check({tag, " unitClk"}, 64'(unitClk), 64'(expectOut()));
    check({tag, " trigCount"}, 64'(trigCount), 64'(mCount));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [PHASES-1:0] prevRaw;
    logic [PHASES-1:0] raw;
    int highCnt [PHASES];
    int sinceToggle;
    int periodOk;
    logic [PHASES-1:0] prevOut;
    void'($urandom(32'd4711));
    @(negedge clk);
    doReset();
    // R1: first sampled state after reset
    check("R1 reset pattern", 64'(unitClk), 64'(oddBits()));
    check("R1 count zero", 64'(trigCount), 64'd0);

    // R7: a single trigger shows after the same edge
    step(1'b1, 1'b1);
    checkAll("R7 single trigger");
    check("R2 stage0 loaded", 64'(unitClk[0]), 64'd1);

    // R3: held low, nothing moves
    for (int i = 0; i < 20; i++) begin
      step(1'b0, 1'b1);
      checkAll("R3 hold");
    end

    // R6: gear toggling without triggers alters only odd outputs
    for (int i = 0; i < 8; i++) begin
      step(1'b0, i[0]);
      checkAll("R6 gear toggle");
      check("R6 even outputs", 64'(unitClk & ~oddBits()), 64'(mRing & ~oddBits()));
    end

    // R2/R3/R5/R6: random triggers and gear
    for (int i = 0; i < 3000; i++) begin
      step(1'($urandom % 2), ($urandom % 8) != 0);
      checkAll("R2 R5 random");
    end

    // R4/R8: held trigger, lag and duty cycle
    doReset();
    step(1'b0, 1'b1);
    prevRaw = unitClk ^ oddBits();
    prevOut = unitClk;
    sinceToggle = 0;
    periodOk = 1;
    for (int k = 0; k < PHASES; k++) highCnt[k] = 0;
    for (int i = 0; i < 6 * PHASES; i++) begin
      step(1'b1, 1'b1);
      raw = unitClk ^ oddBits();
      check("R4 lag", 64'(raw[PHASES-1:1]), 64'(prevRaw[PHASES-2:0]));
      sinceToggle++;
      if (unitClk[0] != prevOut[0]) begin
        if (i >= PHASES && sinceToggle != PHASES) periodOk = 0;
        sinceToggle = 0;
      end
      if (i >= 2 * PHASES && i < 4 * PHASES)
        for (int k = 0; k < PHASES; k++) highCnt[k] += int'(unitClk[k]);
      prevRaw = raw;
      prevOut = unitClk;
    end
    check("R4 period", 64'(periodOk), 64'd1);
    for (int k = 0; k < PHASES; k++)
      check("R8 duty", 64'(highCnt[k]), 64'(PHASES));

    // R5: full counter wrap with held trigger
    doReset();
    for (int i = 0; i < (1 << COUNT_W); i++) begin
      step(1'b1, 1'b1);
      if (i % 64 == 0) checkAll("R5 wrap run");
    end
    check("R5 wrapped count", 64'(trigCount), 64'd0);
    check("R5 ring home", 64'(unitClk), 64'(oddBits()));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule